// File: doc/BRIEF.md
# Rail Retarget Sequencer

This block moves one rail of a multi-rail power controller to a new output voltage without tripping any of its own protection thresholds during the move. It sits in front of a PMBus master and hands it one command at a time. When the voltage goes down, the undervoltage-side limits are lowered before the output set point, and the overvoltage-side limits follow it. When the voltage goes up, the same writes run in the opposite order. In both directions the two margin set points go first because they have no effect in normal operation. The voltage itself is never a ceiling write: the block does not touch the maximum-output register.

A start pulse latches the rail's page number, nine precomputed 16-bit words, a direction bit and a commit enable. The block then sends a one-byte page select and nine word writes. When commit is enabled, it also sends a data-less command that saves the operating settings as power-on defaults. The master returns one response per command. A NACK or a PEC error on any response ends the sequence at once, and the block reports the index of the step that failed. The command interface uses valid/ready. The block raises `cmd_valid` and holds the command stable until the master takes it with `cmd_ready`. It then sends nothing more until the response for that command arrives on `rsp_valid`. The response path has no back-pressure: the master may pulse `rsp_valid` at any time.

Top module: `rail_retarget_seq`

## Requirements
- R1: After reset, `busy`, `cmd_valid`, `done` and `fail` are 0.
- R2: The first command of every sequence is a page select. It has code 0x00, kind 0 (byte write), and `cmd_data` holds the latched page number in its low bits with zeros above.
- R3: With `raise`=0, steps 1..9 are word writes (kind 1) with codes 0x25, 0x26, 0x5E, 0x5F, 0x43, 0x44, 0x21, 0x42, 0x40. Each carries its matching word from `prm_words`, where slot k is bits [16k+15:16k]. The slots, in order, are: margin high (0), margin low (1), power-good on (2), power-good off (3), UV warn (4), UV fault (5), output set point (6), OV warn (7), OV fault (8).
- R4: With `raise`=1, steps 1..9 are word writes with codes 0x25, 0x26, 0x40, 0x42, 0x21, 0x44, 0x43, 0x5F, 0x5E. Each carries its own slot's word.
- R5: With `commit`=1, step 10 is a send-byte command (kind 2) with code 0x11 and data 0. With `commit`=0, the sequence ends after step 9 and no 0x11 command is sent.
- R6: A response with `rsp_nack` or `rsp_pec_err` set ends the sequence. One cycle later, `fail` pulses, `fail_step` shows the failing step index (0 for page, 1..9 for the word writes, 10 for the store), `busy` is 0, and no further command is issued.
- R7: `cmd_valid`, once high, stays high with stable code, data and kind until `cmd_ready` is seen. After the transfer, `cmd_valid` stays low until the response arrives.
- R8: `start` has no effect while `busy` is 1. `rsp_valid` has no effect unless a response is awaited.
- R9: Command code 0x24 (maximum output voltage) is never issued.
- R10: After a good response to the last step, `done` pulses for exactly one cycle while `busy` drops to 0. `done` and `fail` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (sampled when idle) |
| page | input | 8 | Page number of the target rail |
| prm_words | input | 144 | Nine 16-bit parameter words, slot k in bits [16k+15:16k] |
| raise | input | 1 | 0: voltage falls, 1: voltage rises |
| commit | input | 1 | Append the store-defaults command |
| cmd_valid | output | 1 | Command offered to the bus master |
| cmd_ready | input | 1 | Bus master accepts the command |
| cmd_code | output | 8 | Command code byte |
| cmd_data | output | 16 | Data (byte in low bits, word, or zero) |
| cmd_kind | output | 2 | 0 byte write, 1 word write, 2 send byte |
| rsp_valid | input | 1 | Response for the outstanding command |
| rsp_nack | input | 1 | Response carries a NACK |
| rsp_pec_err | input | 1 | Response carries a PEC mismatch |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on success |
| fail | output | 1 | One-cycle pulse on abort |
| fail_step | output | 4 | Index of the failing step, held until the next start |

## Verification
The hardest case to reach is an abort at a chosen step after a long run of good responses, above all a refusal of the page select itself and a failure on the final store. The bench plays the bus master. It holds back `cmd_ready` for a set number of cycles, and it plants a NACK or a PEC error at the step index named in each vector. It then confirms the reported step and that the command port stays quiet afterwards. The same runs also pulse `start` in the middle of a sequence, to show the latched words and order survive it.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  localparam int NSLOT  = 9;
  localparam int STEP_W = $clog2(NSLOT + 2);

  typedef enum logic [1:0] {
    K_BYTE = 2'd0,
    K_WORD = 2'd1,
    K_SEND = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2
  } st_e;

  localparam logic [7:0] CODE_PAGE  = 8'h00;
  localparam logic [7:0] CODE_STORE = 8'h11;

  // Command code of each parameter slot
  function automatic logic [7:0] slot_code(input logic [STEP_W-1:0] s);
    case (s)
      4'd0:    slot_code = 8'h25; // margin high
      4'd1:    slot_code = 8'h26; // margin low
      4'd2:    slot_code = 8'h5E; // power good on
      4'd3:    slot_code = 8'h5F; // power good off
      4'd4:    slot_code = 8'h43; // UV warn
      4'd5:    slot_code = 8'h44; // UV fault
      4'd6:    slot_code = 8'h21; // output set point
      4'd7:    slot_code = 8'h42; // OV warn
      default: slot_code = 8'h40; // OV fault
    endcase
  endfunction
endpackage

// File: rtl/rrs_order.sv
module rrs_order
  import rrs_pkg::*;
#(
  parameter int N_SLOT = NSLOT
) (
  input  logic [STEP_W-1:0] step,
  input  logic              raise,
  output logic [STEP_W-1:0] slot
);
  localparam int N_MARGIN = 2;

  always_comb begin
    if (step == '0 || int'(step) > N_SLOT)
      slot = '0;
    else if (!raise || int'(step) <= N_MARGIN)
      slot = step - STEP_W'(1);
    else
      slot = STEP_W'(N_SLOT + N_MARGIN) - step;
  end
endmodule

// File: rtl/rrs_cmd_build.sv
module rrs_cmd_build
  import rrs_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int WORD_W = 16,
  parameter int N_SLOT = NSLOT
) (
  input  logic [STEP_W-1:0]        step,
  input  logic [STEP_W-1:0]        slot,
  input  logic [PAGE_W-1:0]        page_q,
  input  logic [N_SLOT*WORD_W-1:0] words_q,
  output logic [7:0]               code,
  output logic [WORD_W-1:0]        data,
  output logic [1:0]               kind
);
  logic [WORD_W-1:0] word_arr [N_SLOT];

  for (genvar g = 0; g < N_SLOT; g++) begin : g_unpack
    assign word_arr[g] = words_q[g*WORD_W +: WORD_W];
  end

  always_comb begin
    if (step == '0) begin
      code = CODE_PAGE;
      data = {{(WORD_W-PAGE_W){1'b0}}, page_q};
      kind = K_BYTE;
    end else if (int'(step) <= N_SLOT) begin
      code = slot_code(slot);
      data = word_arr[slot];
      kind = K_WORD;
    end else begin
      code = CODE_STORE;
      data = '0;
      kind = K_SEND;
    end
  end
endmodule

// File: rtl/rail_retarget_seq.sv
module rail_retarget_seq
  import rrs_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int WORD_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [PAGE_W-1:0]       page,
  input  logic [NSLOT*WORD_W-1:0] prm_words,
  input  logic                    raise,
  input  logic                    commit,
  output logic                    cmd_valid,
  input  logic                    cmd_ready,
  output logic [7:0]              cmd_code,
  output logic [WORD_W-1:0]       cmd_data,
  output logic [1:0]              cmd_kind,
  input  logic                    rsp_valid,
  input  logic                    rsp_nack,
  input  logic                    rsp_pec_err,
  output logic                    busy,
  output logic                    done,
  output logic                    fail,
  output logic [STEP_W-1:0]       fail_step
);
  localparam logic [STEP_W-1:0] LAST_WR    = STEP_W'(NSLOT);
  localparam logic [STEP_W-1:0] LAST_STORE = STEP_W'(NSLOT + 1);

  st_e                     st;
  logic [STEP_W-1:0]       step;
  logic [PAGE_W-1:0]       page_q;
  logic [NSLOT*WORD_W-1:0] words_q;
  logic                    raise_q;
  logic                    commit_q;
  logic [STEP_W-1:0]       slot;
  logic [STEP_W-1:0]       last_step;
  logic                    bad_rsp;

  assign last_step = commit_q ? LAST_STORE : LAST_WR;
  assign bad_rsp   = rsp_nack | rsp_pec_err;
  assign cmd_valid = (st == S_ISSUE);
  assign busy      = (st != S_IDLE);

  rrs_order #(.N_SLOT(NSLOT)) u_order (
    .step  (step),
    .raise (raise_q),
    .slot  (slot)
  );

  rrs_cmd_build #(.PAGE_W(PAGE_W), .WORD_W(WORD_W), .N_SLOT(NSLOT)) u_build (
    .step    (step),
    .slot    (slot),
    .page_q  (page_q),
    .words_q (words_q),
    .code    (cmd_code),
    .data    (cmd_data),
    .kind    (cmd_kind)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      step      <= '0;
      page_q    <= '0;
      words_q   <= '0;
      raise_q   <= 1'b0;
      commit_q  <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_step <= '0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (start) begin
            page_q    <= page;
            words_q   <= prm_words;
            raise_q   <= raise;
            commit_q  <= commit;
            step      <= '0;
            fail_step <= '0;
            st        <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          if (cmd_ready) st <= S_WAIT;
        end
        S_WAIT: begin
          if (rsp_valid) begin
            if (bad_rsp) begin
              fail      <= 1'b1;
              fail_step <= step;
              st        <= S_IDLE;
            end else if (step == last_step) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              step <= step + STEP_W'(1);
              st   <= S_ISSUE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rail_retarget_seq_chk.sv
module rail_retarget_seq_chk #(
  parameter int WORD_W = 16,
  parameter int STEP_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [7:0]        cmd_code,
  input logic [WORD_W-1:0] cmd_data,
  input logic [1:0]        cmd_kind,
  input logic              rsp_valid,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [STEP_W-1:0] fail_step
);
  a_r7_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_code) && $stable(cmd_data) && $stable(cmd_kind));

  a_r7_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid);

  a_r2_page_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cmd_valid && cmd_code == 8'h00 && cmd_kind == 2'd0);

  a_r9_no_vout_max: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_code != 8'h24);

  a_r10_done_fail_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !cmd_valid);

  a_r6_fail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !busy && !cmd_valid);

  a_r6_fail_step_held: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !$rose(busy) && $past(!busy) |-> $stable(fail_step));
endmodule

bind rail_retarget_seq rail_retarget_seq_chk #(.WORD_W(WORD_W), .STEP_W(rrs_pkg::STEP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_code  (cmd_code),
  .cmd_data  (cmd_data),
  .cmd_kind  (cmd_kind),
  .rsp_valid (rsp_valid),
  .busy      (busy),
  .done      (done),
  .fail      (fail),
  .fail_step (fail_step)
);

// File: tb/rail_retarget_seq_tb_top.sv
module rail_retarget_seq_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [7:0]   page = '0;
  logic [143:0] prm_words = '0;
  logic         raise = 1'b0;
  logic         commit = 1'b0;
  logic         cmd_valid;
  logic         cmd_ready = 1'b0;
  logic [7:0]   cmd_code;
  logic [15:0]  cmd_data;
  logic [1:0]   cmd_kind;
  logic         rsp_valid = 1'b0;
  logic         rsp_nack = 1'b0;
  logic         rsp_pec_err = 1'b0;
  logic         busy, done, fail;
  logic [3:0]   fail_step;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rail_retarget_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .page(page), .prm_words(prm_words),
    .raise(raise), .commit(commit), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_data(cmd_data), .cmd_kind(cmd_kind),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_pec_err(rsp_pec_err),
    .busy(busy), .done(done), .fail(fail), .fail_step(fail_step)
  );

  // Expected codes: falling order, rising order, and the slot each step carries
  localparam logic [7:0] CODE_LO [9] = '{8'h25, 8'h26, 8'h5E, 8'h5F, 8'h43, 8'h44, 8'h21, 8'h42, 8'h40};
  localparam logic [7:0] CODE_HI [9] = '{8'h25, 8'h26, 8'h40, 8'h42, 8'h21, 8'h44, 8'h43, 8'h5F, 8'h5E};
  localparam int         SLOT_HI [9] = '{0, 1, 8, 7, 6, 5, 4, 3, 2};

  // {raise, commit, pec, rdly[1:0], bad[3:0], page[7:0]}; bad = 15 means none
  localparam int NVEC = 8;
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 2'd0, 4'hF, 8'h03},
    {1'b1, 1'b0, 1'b0, 2'd2, 4'hF, 8'h01},
    {1'b0, 1'b1, 1'b0, 2'd1, 4'hF, 8'h00},
    {1'b1, 1'b1, 1'b0, 2'd0, 4'hF, 8'h05},
    {1'b0, 1'b0, 1'b0, 2'd0, 4'h0, 8'h07},
    {1'b1, 1'b1, 1'b1, 2'd0, 4'h4, 8'h02},
    {1'b0, 1'b1, 1'b0, 2'd3, 4'hA, 8'h04},
    {1'b1, 1'b0, 1'b0, 2'd1, 4'h9, 8'h06}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic run_seq(input logic [16:0] v);
    logic       dir   = v[16];
    logic       cmt   = v[15];
    logic       pec   = v[14];
    int         rdly  = int'(v[13:12]);
    int         bad   = int'(v[11:8]);
    logic [7:0] pg    = v[7:0];
    int         nst   = cmt ? 11 : 10;
    logic [15:0] w [9];
    for (int i = 0; i < 9; i++) begin
      w[i] = {pg, 4'h5, 4'(i)};
      prm_words[i*16 +: 16] = w[i];
    end
    @(negedge clk);
    page = pg; raise = dir; commit = cmt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int s = 0; s < nst; s++) begin
      logic [7:0]  ecode;
      logic [15:0] edata;
      logic [1:0]  ekind;
      int          t = 0;
      while (!cmd_valid && t < 50) begin
        @(negedge clk);
        t++;
      end
      chk(cmd_valid, "R7 command offered", 32'(cmd_valid), 1);
      for (int d = 0; d < rdly; d++) @(negedge clk);
      chk(cmd_valid, "R7 valid held while not ready", 32'(cmd_valid), 1);
      if (s == 0) begin
        ecode = 8'h00; edata = {8'h00, pg}; ekind = 2'd0;
      end else if (s <= 9) begin
        ecode = dir ? CODE_HI[s-1] : CODE_LO[s-1];
        edata = dir ? w[SLOT_HI[s-1]] : w[s-1];
        ekind = 2'd1;
      end else begin
        ecode = 8'h11; edata = 16'h0; ekind = 2'd2;
      end
      if (s == 0) chk(cmd_code == ecode, "R2 page code", 32'(cmd_code), 32'(ecode));
      else if (s == 10) chk(cmd_code == ecode, "R5 store code", 32'(cmd_code), 32'(ecode));
      else if (dir) chk(cmd_code == ecode, "R4 rising order code", 32'(cmd_code), 32'(ecode));
      else chk(cmd_code == ecode, "R3 falling order code", 32'(cmd_code), 32'(ecode));
      chk(cmd_data == edata, "R2/R3/R4/R5 data", 32'(cmd_data), 32'(edata));
      chk(cmd_kind == ekind, "R2/R3/R4/R5 kind", 32'(cmd_kind), 32'(ekind));
      chk(cmd_code != 8'h24, "R9 no max-output write", 32'(cmd_code), 32'h24);
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
      chk(!cmd_valid, "R7 no second command before response", 32'(cmd_valid), 0);
      // stray start mid-sequence must not disturb it (R8)
      if (s == 1) begin
        start = 1'b1; page = 8'hEE; raise = ~dir; commit = ~cmt;
        prm_words = '1;
      end
      rsp_valid = 1'b1;
      rsp_nack = (s == bad) && !pec;
      rsp_pec_err = (s == bad) && pec;
      @(negedge clk);
      rsp_valid = 1'b0; rsp_nack = 1'b0; rsp_pec_err = 1'b0; start = 1'b0;
      if (s == bad) begin
        chk(fail == 1'b1, "R6 fail pulse", 32'(fail), 1);
        chk(fail_step == 4'(bad), "R6 fail step", 32'(fail_step), 32'(bad));
        chk(!busy && !done, "R6 idle after abort", {busy, done}, 0);
        for (int q = 0; q < 3; q++) begin
          @(negedge clk);
          chk(!cmd_valid && !fail, "R6 quiet after abort", {cmd_valid, fail}, 0);
        end
        chk(fail_step == 4'(bad), "R6 fail step held", 32'(fail_step), 32'(bad));
        return;
      end
      if (s == nst - 1) begin
        chk(done == 1'b1 && !busy, "R10 done with busy low", {done, busy}, 2);
        chk(!fail, "R10 no fail with done", 32'(fail), 0);
        @(negedge clk);
        chk(!done && !cmd_valid, "R10/R5 single done, nothing after", {done, cmd_valid}, 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !cmd_valid && !done && !fail, "R1 reset state",
        {busy, cmd_valid, done, fail}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !cmd_valid, "R1 idle after reset release", {busy, cmd_valid}, 0);
    for (int k = 0; k < NVEC; k++) run_seq(VEC[k]);
    // stray response while idle (R8)
    @(negedge clk);
    rsp_valid = 1'b1; rsp_nack = 1'b1;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_nack = 1'b0;
    chk(!fail && !done && !busy, "R8 stray response ignored", {fail, done, busy}, 0);
    @(negedge clk);
    chk(!cmd_valid && !busy, "R8 still idle", {cmd_valid, busy}, 0);
    // reset in the middle of a sequence returns to idle (R1)
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cmd_valid, "R2 sequence begins", 32'(cmd_valid), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !cmd_valid, "R1 reset mid-sequence", {busy, cmd_valid}, 0);
    rst_n = 1'b1;
    run_seq(VEC[0]);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule